// File: doc/BRIEF.md
# Word Rotator and Mask Unit

This datapath stage takes a 36-bit word, rotates it circularly toward the more significant end, and can then clear every bit above a chosen width. The rotation amount comes from a six-bit literal in the control word or from a small count register. The mask width comes from a six-bit literal or from a separate mask-size register. Both registers capture the low six bits of the data input on a single-cycle strobe.

A three-way output selector picks what leaves the stage. It can send out the rotated word as it is, the rotated word ANDed with the mask, or the mask alone, which serves as a constant source. A left-half override replaces the generated mask with ones in the upper 18 bits and zeros in the lower 18 bits. The override ignores the width selection. Apart from the two registers, the path from the inputs to the output is combinational.

Top module: `word_rotmask`

## Requirements
- R1: With `rot_use_reg`=0, `data_out` in pass mode equals `data_in` rotated circularly left by `rot_lit`. Input bit i appears at output bit (i+count) mod 36, and a count of 0 leaves the word unchanged.
- R2: Rotate counts 36 to 63, from either source, act as the count minus 36.
- R3: With `rot_use_reg`=1, the stage uses the count register. A clock edge with `rot_cnt_load`=1 writes `data_in[5:0]` into that register. The new value takes effect from the following cycle, and the loading cycle still uses the old value.
- R4: Reset, active low on `rst_n`, clears both the count register and the mask-size register to zero.
- R5: A mask width N sets bits N-1..0 to ones and all higher bits to zeros. N=0 gives all zeros, N=18 gives exactly the right half, and any N of 36 or more gives all ones.
- R6: With `mask_use_reg`=0, the mask width is `mask_lit`. With `mask_use_reg`=1, it is the mask-size register. A clock edge with `mask_size_load`=1 writes `data_in[5:0]` into that register.
- R7: `out_mode` works as follows: 2'b00 outputs the rotated word, 2'b01 outputs the rotated word ANDed with the mask, and 2'b10 and 2'b11 both output the mask itself.
- R8: `left_half`=1 makes the mask equal to ones in bits 35..18 and zeros in bits 17..0, whatever the width selection is.
- R9: A register whose strobe is low keeps its value, even when `data_in` changes.
- R10: Both registers can load in the same cycle, and each captures `data_in[5:0]` without affecting the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 36 | Word to rotate; its low 6 bits also load the registers |
| rot_use_reg | input | 1 | 1: rotate by count register, 0: by `rot_lit` |
| rot_lit | input | 6 | Literal rotate count |
| rot_cnt_load | input | 1 | Load strobe for the count register |
| mask_use_reg | input | 1 | 1: mask width from mask-size register, 0: from `mask_lit` |
| mask_lit | input | 6 | Literal mask width |
| mask_size_load | input | 1 | Load strobe for the mask-size register |
| left_half | input | 1 | Force the mask to the upper-half pattern |
| out_mode | input | 2 | Output selection (see R7) |
| data_out | output | 36 | Result word |

## Verification
A register load and a rotate or mask that reads that same register can fall in the same cycle. The bench raises `rot_cnt_load` and `mask_size_load` while the register sources are selected. It then samples `data_out` before the edge and expects the old count and width to apply. After the edge it expects the new ones. It also loads both registers together to confirm that neither load disturbs the other.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int WORD_W = 36;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        OUT_ROT     = 2'b00,
        OUT_MASKED  = 2'b01,
        OUT_MASK    = 2'b10,
        OUT_MASK_B  = 2'b11
    } out_mode_e;

endpackage

// File: rtl/rotmask_cnt_regs.sv
module rotmask_cnt_regs #(
    parameter int CNT_W = rotmask_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rot_load,
    input  logic             msk_load,
    output logic [CNT_W-1:0] rot_cnt_q,
    output logic [CNT_W-1:0] msk_size_q
);

    typedef struct packed {
        logic [CNT_W-1:0] rot_cnt;
        logic [CNT_W-1:0] msk_size;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rot_load) regs_d.rot_cnt  = load_val;
        if (msk_load) regs_d.msk_size = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rot_cnt_q  = regs_q.rot_cnt;
    assign msk_size_q = regs_q.msk_size;

    assert_rot_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rot_load |=> (rot_cnt_q == $past(load_val)));

    assert_msk_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msk_load |=> (msk_size_q == $past(load_val)));

    assert_rot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rot_load |=> $stable(rot_cnt_q));

    assert_msk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !msk_load |=> $stable(msk_size_q));

endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
    parameter int WORD_W = rotmask_pkg::WORD_W,
    parameter int CNT_W  = rotmask_pkg::CNT_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] word_out
);

    // One fixed rotation per count bit; composing them gives a rotate by
    // the full count, which is reduced modulo WORD_W without a divider.
    logic [WORD_W-1:0] stage [0:CNT_W];

    assign stage[0] = word_in;

    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        localparam int AMT = (1 << i) % WORD_W;
        if (AMT == 0) begin : g_none
            assign stage[i+1] = stage[i];
        end else begin : g_rot
            assign stage[i+1] = count[i]
                ? {stage[i][WORD_W-1-AMT:0], stage[i][WORD_W-1:WORD_W-AMT]}
                : stage[i];
        end
    end

    assign word_out = stage[CNT_W];

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
    parameter int WORD_W = rotmask_pkg::WORD_W,
    parameter int CNT_W  = rotmask_pkg::CNT_W
) (
    input  logic [CNT_W-1:0]  width,
    input  logic              left_half,
    output logic [WORD_W-1:0] mask
);

    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] by_width;
    logic [WORD_W-1:0] upper_half;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign by_width[i] = (32'(width) > 32'(i));
        if (i >= HALF) begin : g_hi
            assign upper_half[i] = 1'b1;
        end else begin : g_lo
            assign upper_half[i] = 1'b0;
        end
    end

    assign mask = left_half ? upper_half : by_width;

endmodule

// File: rtl/word_rotmask.sv
module word_rotmask #(
    parameter int WORD_W = rotmask_pkg::WORD_W,
    parameter int CNT_W  = rotmask_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_in,
    input  logic              rot_use_reg,
    input  logic [CNT_W-1:0]  rot_lit,
    input  logic              rot_cnt_load,
    input  logic              mask_use_reg,
    input  logic [CNT_W-1:0]  mask_lit,
    input  logic              mask_size_load,
    input  logic              left_half,
    input  logic [1:0]        out_mode,
    output logic [WORD_W-1:0] data_out
);
    import rotmask_pkg::*;

    localparam int HALF = WORD_W / 2;

    logic [CNT_W-1:0]  rot_cnt_q, msk_size_q;
    logic [CNT_W-1:0]  rot_sel, width_sel;
    logic [WORD_W-1:0] rot_word, mask_word;
    out_mode_e         mode;

    rotmask_cnt_regs #(.CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_val   (data_in[CNT_W-1:0]),
        .rot_load   (rot_cnt_load),
        .msk_load   (mask_size_load),
        .rot_cnt_q  (rot_cnt_q),
        .msk_size_q (msk_size_q)
    );

    assign rot_sel   = rot_use_reg  ? rot_cnt_q  : rot_lit;
    assign width_sel = mask_use_reg ? msk_size_q : mask_lit;

    rotmask_rotator #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_rot (
        .word_in  (data_in),
        .count    (rot_sel),
        .word_out (rot_word)
    );

    rotmask_maskgen #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_mask (
        .width     (width_sel),
        .left_half (left_half),
        .mask      (mask_word)
    );

    assign mode = out_mode_e'(out_mode);

    always_comb begin
        unique case (mode)
            OUT_ROT:    data_out = rot_word;
            OUT_MASKED: data_out = rot_word & mask_word;
            OUT_MASK,
            OUT_MASK_B: data_out = mask_word;
            default:    data_out = rot_word;
        endcase
    end

    assert_zero_rot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00 && !rot_use_reg && rot_lit == '0) |-> (data_out == data_in));

    assert_and_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b01) |-> ((data_out & ~rot_word) == '0));

    assert_mask_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode[1] && !left_half) |->
            ((data_out & (data_out + {{(WORD_W-1){1'b0}}, 1'b1})) == '0));

    assert_left_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (left_half && out_mode != 2'b00) |-> (data_out[HALF-1:0] == '0));

    assert_pop_rot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |-> ($countones(data_out) == $countones(data_in)));

endmodule

// File: tb/test_word_rotmask.sv
module test_word_rotmask;

    localparam int W = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          rot_use_reg = 1'b0;
    logic [5:0]    rot_lit = '0;
    logic          rot_cnt_load = 1'b0;
    logic          mask_use_reg = 1'b0;
    logic [5:0]    mask_lit = '0;
    logic          mask_size_load = 1'b0;
    logic          left_half = 1'b0;
    logic [1:0]    out_mode = 2'b00;
    logic [W-1:0]  data_out;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    word_rotmask i_word_rotmask (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .rot_use_reg(rot_use_reg), .rot_lit(rot_lit), .rot_cnt_load(rot_cnt_load),
        .mask_use_reg(mask_use_reg), .mask_lit(mask_lit), .mask_size_load(mask_size_load),
        .left_half(left_half), .out_mode(out_mode), .data_out(data_out)
    );

    function automatic logic [W-1:0] ref_rot(input logic [W-1:0] d, input int c);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W; i++) r[(i + c) % W] = d[i];
        return r;
    endfunction

    function automatic logic [W-1:0] ref_mask(input int n, input bit lh);
        logic [W-1:0] m = '0;
        for (int i = 0; i < W; i++) m[i] = lh ? (i >= W/2) : (i < n);
        return m;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (data_out !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, data_out, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] d, input bit ru, input int rl,
                         input bit mu, input int ml, input logic [1:0] md, input bit lh);
        @(negedge clk);
        data_in = d; rot_use_reg = ru; rot_lit = 6'(rl);
        mask_use_reg = mu; mask_lit = 6'(ml); out_mode = md; left_half = lh;
        rot_cnt_load = 1'b0; mask_size_load = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        drive(36'h0_0000_0001, 1, 0, 1, 0, 2'b00, 0);
        check("R4 count reg zero", 36'h0_0000_0001);
        drive(36'h0_0000_0001, 1, 0, 1, 0, 2'b10, 0);
        check("R4 mask reg zero", '0);
    endtask

    task automatic t_literal_rot();
        logic [W-1:0] pats [4] = '{36'h0_0000_0001, 36'h8_0000_0000, 36'h1_2345_6789, 36'hF_0F0F_0A5C};
        int counts [4] = '{0, 1, 17, 35};
        foreach (pats[p]) foreach (counts[c]) begin
            drive(pats[p], 0, counts[c], 0, 0, 2'b00, 0);
            check("R1 literal rotate", ref_rot(pats[p], counts[c]));
        end
    endtask

    task automatic t_big_counts();
        int counts [3] = '{36, 40, 63};
        foreach (counts[c]) begin
            drive(36'h1_2345_6789, 0, counts[c], 0, 0, 2'b00, 0);
            check("R2 count above 35", ref_rot(36'h1_2345_6789, counts[c] - 36));
        end
    endtask

    task automatic t_reg_rot();
        // load 5 while using the register: this cycle still sees count 0
        drive(36'h0_0000_0005, 1, 0, 0, 0, 2'b00, 0);
        rot_cnt_load = 1'b1; #1;
        check("R3 same-cycle old count", 36'h0_0000_0005);
        @(negedge clk); rot_cnt_load = 1'b0; data_in = 36'h0_0000_0001; #1;
        check("R3 new count after edge", ref_rot(36'h1, 5));
        // strobe low, data changes, count holds
        drive(36'h0_0000_003F, 1, 0, 0, 0, 2'b00, 0);
        @(negedge clk); #1;
        check("R9 count holds", ref_rot(36'h3F, 5));
        drive(36'h0_0000_002A, 1, 0, 0, 0, 2'b00, 0); // 42 -> acts as 6
        rot_cnt_load = 1'b1;
        @(negedge clk); rot_cnt_load = 1'b0; data_in = 36'h8_0000_0000; #1;
        check("R2 register count 42", ref_rot(36'h8_0000_0000, 6));
    endtask

    task automatic t_mask_widths();
        int widths [7] = '{0, 1, 12, 18, 35, 36, 50};
        foreach (widths[w]) begin
            drive('0, 0, 0, 0, widths[w], 2'b10, 0);
            check("R5 mask width", ref_mask(widths[w], 0));
        end
        drive('0, 0, 0, 0, 18, 2'b11, 0);
        check("R7 mode 11 gives mask", 36'h0_0003_FFFF);
    endtask

    task automatic t_masked();
        drive('1, 0, 0, 0, 10, 2'b01, 0);
        check("R7 AND all ones", 36'h0_0000_03FF);
        drive(36'h1_2345_6789, 0, 4, 0, 20, 2'b01, 0);
        check("R7 AND pattern", ref_rot(36'h1_2345_6789, 4) & ref_mask(20, 0));
        drive(36'h1_2345_6789, 0, 4, 0, 20, 2'b00, 0);
        check("R7 pass ignores mask", ref_rot(36'h1_2345_6789, 4));
    endtask

    task automatic t_mask_reg();
        drive(36'h0_0000_000C, 0, 0, 1, 0, 2'b10, 0);
        mask_size_load = 1'b1; #1;
        check("R6 same-cycle old width", ref_mask(0, 0));
        @(negedge clk); mask_size_load = 1'b0; data_in = '1; #1;
        check("R6 width from register", ref_mask(12, 0));
        @(negedge clk); #1;
        check("R9 width holds", ref_mask(12, 0));
    endtask

    task automatic t_left_half();
        drive('0, 0, 0, 0, 5, 2'b10, 1);
        check("R8 override mask", 36'hF_FFFC_0000);
        drive(36'hA_BCDE_F123, 0, 0, 1, 0, 2'b01, 1);
        check("R8 override AND", 36'hA_BCDE_F123 & 36'hF_FFFC_0000);
    endtask

    task automatic t_dual_load();
        drive(36'h0_0000_0003, 1, 0, 1, 0, 2'b00, 0);
        rot_cnt_load = 1'b1; mask_size_load = 1'b1;
        @(negedge clk); rot_cnt_load = 1'b0; mask_size_load = 1'b0;
        data_in = 36'h0_0000_0001; #1;
        check("R10 dual load count", ref_rot(36'h1, 3));
        out_mode = 2'b10; #1;
        check("R10 dual load width", ref_mask(3, 0));
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_literal_rot();
        t_big_counts();
        t_reg_rot();
        t_mask_widths();
        t_masked();
        t_mask_reg();
        t_left_half();
        t_dual_load();
        finish_run();
    end

endmodule